// File: doc/BRIEF.md
# Two-Channel Phase Interval Counter

The block measures how far a second periodic digital signal lags a first one, counting cycles of its own fast clock. A rising edge on channel A opens a count gate and the next rising edge on channel B closes it, so the gate opens once per signal period. Each closed gate yields one interval count. Intervals are summed over a programmable power-of-two number of periods, and the sum shifted right gives the average. The average appears on an output bus with a one-cycle done strobe. Both inputs are already-squared logic levels. Each is brought into the clock domain by a two-flop synchroniser followed by a rising-edge detector, so both channels see the same latency.

For signals too fast for the clock (the clock should run at least ten times faster than the signal), a per-channel edge prescaler passes only every 2^k-th rising edge. Averaging then runs over these longer periods. Two error conditions set sticky flags: a second start edge while the gate is still open, and a gate held open long enough to saturate the interval counter.

The gate controller has two states. In GATE_CLOSED a start edge takes the transition "open" to GATE_OPEN. In GATE_OPEN a stop edge takes the transition "close" back to GATE_CLOSED; a start edge without a stop takes "restart", which stays in GATE_OPEN. The averager also has two states. AVG_IDLE waits for the first interval of a batch and takes "begin" to AVG_COLLECT, unless the length is one, in which case it takes "finish-single" and stays. In AVG_COLLECT the last interval of the batch takes "finish" back to AVG_IDLE.

Top module: `phase_interval_meter`

## Requirements
- R1: After reset, avg_out is 0 and avg_done, ovf_flag and overlap_flag are 0.
- R2: An interval count equals the number of clock cycles between the sampled rising edge of ch_a that opened the gate and the sampled rising edge of ch_b that closed it. Both channels have equal synchroniser latency. An input that is asynchronous to the clock can therefore be off by one count, depending on where its edge falls within a clock cycle.
- R3: A rising edge of ch_b while the gate is closed is ignored: it produces no interval and does not change the next measured result.
- R4: A rising edge of ch_a while the gate is open (with no ch_b edge in the same cycle) restarts the interval count from that edge and sets overlap_flag, which stays 1 until reset.
- R5: With avg_sel = k (0 to 2^AVG_W-1), a batch holds 2^k consecutive intervals and avg_out is their sum shifted right by k (truncating). k is captured when the batch's first interval arrives, and batches follow one another with no gap.
- R6: avg_done is high for exactly one cycle per batch, in the cycle avg_out takes the new average; avg_out holds its value at all other times.
- R7: The interval counter saturates at 2^CNT_W-1. A gate that reaches this value sets ovf_flag, which stays 1 until reset, and the saturated value is used as the interval.
- R8: With pre_sel = k, each channel passes only the rising edges whose per-channel edge count since reset (starting at 0) is a multiple of 2^k.
- R9: If edges on ch_a and ch_b are seen in the same cycle while the gate is open, the stop wins: the interval completes, the gate closes and the start edge is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_a | input | 1 | Start channel, squared signal |
| ch_b | input | 1 | Stop channel, squared signal |
| avg_sel | input | AVG_W | log2 of the averaging length |
| pre_sel | input | PRE_W | log2 of the edge prescale ratio |
| avg_out | output | CNT_W | Averaged interval count |
| avg_done | output | 1 | One-cycle strobe for a new average |
| ovf_flag | output | 1 | Sticky interval-counter saturation flag |
| overlap_flag | output | 1 | Sticky start-while-open flag |

## Verification
The bench goes after the offsets that expose off-by-one errors. An interval of one cycle must read 1; a gate that counted its start cycle or missed its first increment would read 0 or 2. Averages are chosen so that truncation matters, such as 15 over 2 giving 7, so a rounding or wrong-shift design fails. The bench also drives a lone stop edge, a double start, a start and stop in the same cycle, and a gate held open past the counter range. A design that accepted the stray stop, kept the first start, let the start win, or wrapped the counter would report a different average or leave a flag clear. A prescaled run checks that only edges on a multiple of the ratio are paired, which a design pairing the wrong edges would get wrong.

// File: rtl/pim_pkg.sv
package pim_pkg;

    typedef enum logic {
        GATE_CLOSED = 1'b0,
        GATE_OPEN   = 1'b1
    } gate_state_t;

    typedef enum logic {
        AVG_IDLE    = 1'b0,
        AVG_COLLECT = 1'b1
    } avg_state_t;

endpackage

// File: rtl/pim_edge_chan.sv
// One input channel: two-flop synchroniser, rising-edge detector and
// an edge decimator that keeps every 2^pre_sel-th edge.
module pim_edge_chan #(
    parameter int PRE_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    input  logic [PRE_W-1:0] pre_sel,
    output logic             edge_o
);
    localparam int DIV_W = (1 << PRE_W) - 1;

    logic             sync1, sync2, prev;
    logic             rise;
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] keep_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            prev  <= 1'b0;
        end else begin
            sync1 <= sig_in;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    assign rise = sync2 & ~prev;

    always_comb begin
        keep_mask = DIV_W'((1 << pre_sel) - 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (rise) begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    assign edge_o = rise && ((div_cnt & keep_mask) == '0);

endmodule

// File: rtl/pim_gate.sv
// Gate controller: counts clock cycles from start edge to stop edge.
module pim_gate
    import pim_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    output logic             iv_valid,
    output logic [CNT_W-1:0] iv_value,
    output logic             ovf_o,
    output logic             ovl_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    gate_state_t      state, state_nx;
    logic [CNT_W-1:0] cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= GATE_CLOSED;
        else        state <= state_nx;
    end

    // transitions: open, close, restart
    always_comb begin
        state_nx = state;
        unique case (state)
            GATE_CLOSED: if (start_i) state_nx = GATE_OPEN;
            GATE_OPEN:   if (stop_i)  state_nx = GATE_CLOSED;
            default:     state_nx = GATE_CLOSED;
        endcase
    end

    // counter and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            iv_valid <= 1'b0;
            iv_value <= '0;
            ovf_o    <= 1'b0;
            ovl_o    <= 1'b0;
        end else begin
            iv_valid <= 1'b0;
            unique case (state)
                GATE_CLOSED: begin
                    if (start_i) cnt <= CNT_W'(1);
                end
                GATE_OPEN: begin
                    if (stop_i) begin
                        iv_valid <= 1'b1;
                        iv_value <= cnt;
                    end else if (start_i) begin
                        cnt   <= CNT_W'(1);
                        ovl_o <= 1'b1;
                    end else if (cnt == CNT_MAX) begin
                        ovf_o <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

endmodule

// File: rtl/pim_avg.sv
// Averager: sums 2^k intervals and shifts right by k.
module pim_avg
    import pim_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int AVG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AVG_W-1:0] avg_sel,
    input  logic             iv_valid,
    input  logic [CNT_W-1:0] iv_value,
    output logic [CNT_W-1:0] avg_out,
    output logic             avg_done
);
    localparam int MAX_SH = (1 << AVG_W) - 1;
    localparam int SUM_W  = CNT_W + MAX_SH;
    localparam int N_W    = MAX_SH + 1;

    avg_state_t       state, state_nx;
    logic [AVG_W-1:0] k_lat;
    logic [N_W-1:0]   n_cnt;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] iv_ext;
    logic [SUM_W-1:0] sum_nx;
    logic [SUM_W-1:0] shifted;
    logic             last;

    assign iv_ext  = {{MAX_SH{1'b0}}, iv_value};
    assign sum_nx  = sum + iv_ext;
    assign shifted = sum_nx >> k_lat;
    assign last    = (n_cnt == N_W'((1 << k_lat) - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= AVG_IDLE;
        else        state <= state_nx;
    end

    // transitions: begin, finish-single, finish
    always_comb begin
        state_nx = state;
        unique case (state)
            AVG_IDLE:    if (iv_valid && avg_sel != '0) state_nx = AVG_COLLECT;
            AVG_COLLECT: if (iv_valid && last)          state_nx = AVG_IDLE;
            default:     state_nx = AVG_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k_lat    <= '0;
            n_cnt    <= '0;
            sum      <= '0;
            avg_out  <= '0;
            avg_done <= 1'b0;
        end else begin
            avg_done <= 1'b0;
            unique case (state)
                AVG_IDLE: begin
                    k_lat <= avg_sel;
                    if (iv_valid) begin
                        if (avg_sel == '0) begin
                            avg_out  <= iv_value;
                            avg_done <= 1'b1;
                        end else begin
                            sum   <= iv_ext;
                            n_cnt <= N_W'(1);
                        end
                    end
                end
                AVG_COLLECT: begin
                    if (iv_valid) begin
                        if (last) begin
                            avg_out  <= shifted[CNT_W-1:0];
                            avg_done <= 1'b1;
                            sum      <= '0;
                            n_cnt    <= '0;
                        end else begin
                            sum   <= sum_nx;
                            n_cnt <= n_cnt + 1'b1;
                        end
                    end
                end
                default: n_cnt <= '0;
            endcase
        end
    end

endmodule

// File: rtl/phase_interval_meter.sv
module phase_interval_meter
    import pim_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int AVG_W = 3,
    parameter int PRE_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ch_a,
    input  logic             ch_b,
    input  logic [AVG_W-1:0] avg_sel,
    input  logic [PRE_W-1:0] pre_sel,
    output logic [CNT_W-1:0] avg_out,
    output logic             avg_done,
    output logic             ovf_flag,
    output logic             overlap_flag
);
    localparam int NCH = 2;

    logic [NCH-1:0]   raw;
    logic [NCH-1:0]   edges;
    logic             iv_valid;
    logic [CNT_W-1:0] iv_value;

    assign raw = {ch_b, ch_a};

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        pim_edge_chan #(.PRE_W(PRE_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .sig_in  (raw[g]),
            .pre_sel (pre_sel),
            .edge_o  (edges[g])
        );
    end

    pim_gate #(.CNT_W(CNT_W)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (edges[0]),
        .stop_i   (edges[1]),
        .iv_valid (iv_valid),
        .iv_value (iv_value),
        .ovf_o    (ovf_flag),
        .ovl_o    (overlap_flag)
    );

    pim_avg #(.CNT_W(CNT_W), .AVG_W(AVG_W)) u_avg (
        .clk      (clk),
        .rst_n    (rst_n),
        .avg_sel  (avg_sel),
        .iv_valid (iv_valid),
        .iv_value (iv_value),
        .avg_out  (avg_out),
        .avg_done (avg_done)
    );

endmodule

// File: rtl/pim_checker.sv
module pim_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] avg_out,
    input logic             avg_done,
    input logic             ovf_flag,
    input logic             overlap_flag
);
    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        avg_done |=> !avg_done);

    // R6
    avg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !avg_done |-> $stable(avg_out));

    // R4
    overlap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_flag |=> overlap_flag);

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

endmodule

bind phase_interval_meter pim_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .avg_out      (avg_out),
    .avg_done     (avg_done),
    .ovf_flag     (ovf_flag),
    .overlap_flag (overlap_flag)
);

// File: tb/sim_phase_interval_meter.sv
`timescale 1ns/1ps
module sim_phase_interval_meter;
    localparam int CNT_W = 8;
    localparam int AVG_W = 3;
    localparam int PRE_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ch_a = 1'b0;
    logic             ch_b = 1'b0;
    logic [AVG_W-1:0] avg_sel = '0;
    logic [PRE_W-1:0] pre_sel = '0;
    logic [CNT_W-1:0] avg_out;
    logic             avg_done;
    logic             ovf_flag;
    logic             overlap_flag;

    int checks = 0;
    int fails  = 0;
    int pcount = 0;
    bit finished = 1'b0;
    int    exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    phase_interval_meter #(.CNT_W(CNT_W), .AVG_W(AVG_W), .PRE_W(PRE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .ch_a(ch_a), .ch_b(ch_b),
        .avg_sel(avg_sel), .pre_sel(pre_sel), .avg_out(avg_out),
        .avg_done(avg_done), .ovf_flag(ovf_flag), .overlap_flag(overlap_flag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_avg(input int v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one period: ch_a rises, ch_b rises d cycles later
    task automatic period(input int d);
        ch_a = 1'b1;
        pcount++;
        idle(d);
        ch_b = 1'b1;
        idle(3);
        ch_a = 1'b0;
        ch_b = 1'b0;
        idle(6);
    endtask

    task automatic batch(input int k, input int offs[], input string tag);
        int sum = 0;
        avg_sel = AVG_W'(k);
        foreach (offs[i]) sum += offs[i];
        expect_avg(sum >> k, tag);
        foreach (offs[i]) period(offs[i]);
        idle(4);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && avg_done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected done", int'(avg_out), -1);
            end else begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(int'(avg_out) == e, t, int'(avg_out), e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        // R1 reset state
        check(avg_out == '0, "R1 avg_out", int'(avg_out), 0);
        check(avg_done == 1'b0, "R1 avg_done", int'(avg_done), 0);
        check(ovf_flag == 1'b0 && overlap_flag == 1'b0, "R1 flags",
              int'({ovf_flag, overlap_flag}), 0);
        rst_n = 1'b1;
        idle(3);

        // R2/R5 basic averaging
        batch(2, '{10, 12, 14, 16}, "R5 avg of four");
        batch(1, '{7, 8}, "R5 truncation");
        batch(0, '{1}, "R2 one-cycle interval");
        batch(3, '{20, 21, 22, 23, 24, 25, 26, 27}, "R5 avg of eight");
        batch(0, '{40}, "R2 single interval");
        // R6 hold between batches
        idle(20);
        check(int'(avg_out) == 40, "R6 avg_out holds", int'(avg_out), 40);

        // R8 prescale by two: only even-numbered edges pair up
        begin
            int offs[4] = '{30, 11, 6, 17};
            int sum = 0;
            pre_sel = 2'd1;
            avg_sel = 3'd1;
            for (int i = 0; i < 4; i++) if (((pcount + i) % 2) == 0) sum += offs[i];
            expect_avg(sum >> 1, "R8 prescaled pairing");
            for (int i = 0; i < 4; i++) period(offs[i]);
            idle(4);
            pre_sel = 2'd0;
        end

        // R9 simultaneous start and stop while open, then R3 lone stop ignored
        avg_sel = 3'd0;
        expect_avg(9, "R9 stop wins");
        expect_avg(5, "R3 lone stop ignored");
        ch_a = 1'b1; idle(3); ch_a = 1'b0; idle(6);
        ch_a = 1'b1; ch_b = 1'b1; idle(3); ch_a = 1'b0; ch_b = 1'b0; idle(6);
        ch_b = 1'b1; idle(3); ch_b = 1'b0; idle(6);
        period(5);
        idle(4);
        check(overlap_flag == 1'b0, "R9 no overlap from dropped start",
              int'(overlap_flag), 0);

        // R4 double start restarts the gate
        expect_avg(5, "R4 restart count");
        ch_a = 1'b1; idle(3); ch_a = 1'b0; idle(7);
        ch_a = 1'b1; idle(5); ch_b = 1'b1; idle(3);
        ch_a = 1'b0; ch_b = 1'b0; idle(10);
        check(overlap_flag == 1'b1, "R4 overlap_flag set", int'(overlap_flag), 1);

        // R7 saturation
        check(ovf_flag == 1'b0, "R7 ovf clear before", int'(ovf_flag), 0);
        expect_avg(255, "R7 saturated interval");
        ch_a = 1'b1; idle(3); ch_a = 1'b0; idle(297);
        ch_b = 1'b1; idle(3); ch_b = 1'b0; idle(10);
        check(ovf_flag == 1'b1, "R7 ovf_flag set", int'(ovf_flag), 1);
        idle(10);
        check(ovf_flag == 1'b1 && overlap_flag == 1'b1, "R4 R7 flags sticky",
              int'({ovf_flag, overlap_flag}), 3);

        check(exp_q.size() == 0, "R6 all averages delivered", exp_q.size(), 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule